// File: doc/BRIEF.md
# One-Time-Programmable Byte Access Controller

This block lets software read and program single bytes of a one-time-programmable array through a small set of byte-wide registers. Software first clears the power-down control. It then loads a byte address, which is split over a low register and a high register, and picks an operation in a function register. Setting the go bit launches the operation. The controller holds a busy status for a fixed number of cycles that depends on the operation. When the operation ends, it records pass or fail and clears the function and go bits, so the next byte can be started by setting them again.

Programming can only turn bits on: the program data is ORed into the stored byte. The result is then compared with the requested byte, and any mismatch is reported as a failure. A request that cannot run is rejected at once with the fail bit set and has no effect on the array. A request cannot run if the array is powered down, if the function bits do not select exactly one operation, if a program is requested without byte mode, or if the address lies beyond the modelled array. The array itself is a behavioural model whose size is a parameter. The register interface is a plain write strobe with a combinational read port, and it has no back-pressure.

Top module: `otpc_top`

## Requirements
- R1: After reset, the power-down register (offset 0x00, bit 0) reads 1. Status (0x30), pass/fail (0x2C) and function (0x20) all read 0, and every array byte reads back as 0x00.
- R2: The byte address is {high register at 0x04 bits 4:0, low register at 0x08 bits 7:0}. Bits 7:5 of the high register read as 0. Bytes at addresses that differ only in the high part are independent.
- R3: With function bit 0 set and a 1 written to go bit 0 (0x28), status bit 0 reads 1 for exactly RD_LAT cycles. After that, the read-data register (0x18) holds the addressed byte and fail reads 0.
- R4: With function bit 1 set and byte mode (0x14 bit 0) set, a program ORs the program-data byte (0x10) into the addressed byte. Fail reads 0 when the resulting byte equals the program data.
- R5: When the ORed byte differs from the program data, fail reads 1 and the array keeps the ORed value.
- R6: A program holds status bit 0 at 1 for exactly PG_LAT cycles.
- R7: When an operation completes or is rejected, the function register and the go bit read 0.
- R8: A go is rejected when the array is powered down, when the function bits are 00 or 11, when a program is requested without byte mode, or when the address is at or above ARRAY_BYTES. A rejected go sets fail in the next cycle, never raises busy, and leaves the array unchanged.
- R9: Register writes made while busy are ignored.
- R10: Fail is cleared when an accepted operation starts, so it always reflects the most recent operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |

## Verification
The hardest situation to reach is a write that lands while an operation is in flight. A busy window lasts only RD_LAT or PG_LAT cycles, so the stimulus launches a read and then issues address and power-down writes on the very next cycles, while status is still high. Once the read is idle, the bench reads those registers back to confirm they are unchanged. A second hard case is the verify failure: it only appears when a byte is programmed a second time with data that lacks bits already set. The stimulus therefore programs one location twice with overlapping patterns, then checks both the fail flag and the ORed value it reads back.

// File: rtl/otpc_pkg.sv
package otpc_pkg;
  localparam int REG_AW = 6;
  localparam int OTP_AW = 13;
  localparam logic [REG_AW-1:0] OFF_PWRDN = 6'h00;
  localparam logic [REG_AW-1:0] OFF_ADHI  = 6'h04;
  localparam logic [REG_AW-1:0] OFF_ADLO  = 6'h08;
  localparam logic [REG_AW-1:0] OFF_PDATA = 6'h10;
  localparam logic [REG_AW-1:0] OFF_MODE  = 6'h14;
  localparam logic [REG_AW-1:0] OFF_RDATA = 6'h18;
  localparam logic [REG_AW-1:0] OFF_FUNC  = 6'h20;
  localparam logic [REG_AW-1:0] OFF_GO    = 6'h28;
  localparam logic [REG_AW-1:0] OFF_FAIL  = 6'h2C;
  localparam logic [REG_AW-1:0] OFF_STAT  = 6'h30;
  localparam logic [1:0] FN_READ = 2'b01;
  localparam logic [1:0] FN_PROG = 2'b10;
endpackage

// File: rtl/otpc_array.sv
module otpc_array #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  output logic [7:0]    rd_byte
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (wr_en) begin
      cells[idx] <= wr_byte;
    end
  end

  assign rd_byte = cells[idx];

  // A write may only add bits to what is stored
  p_or_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_byte & rd_byte) == rd_byte));
endmodule

// File: rtl/otpc_seq.sv
module otpc_seq
  import otpc_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 12,
  localparam int AW = $clog2(ARRAY_BYTES),
  localparam int MAXLAT = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT,
  localparam int CW = $clog2(MAXLAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_pulse,
  input  logic              pwrdn,
  input  logic [1:0]        func,
  input  logic              byte_mode,
  input  logic [OTP_AW-1:0] addr,
  input  logic [7:0]        pdata,
  input  logic [7:0]        cell_byte,
  output logic [AW-1:0]     cell_idx,
  output logic              cell_wr,
  output logic [7:0]        cell_wbyte,
  output logic              busy,
  output logic              fail,
  output logic [7:0]        rbyte,
  output logic              done
);
  logic          busy_q, fail_q, prog_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    rbyte_q;
  logic          in_range, legal, start, reject, finish;
  logic [7:0]    merged;

  assign in_range = int'(addr) < ARRAY_BYTES;
  assign legal = !pwrdn && in_range &&
                 ((func == FN_READ) || (func == FN_PROG && byte_mode));
  assign start  = go_pulse && legal;
  assign reject = go_pulse && !legal;
  assign finish = busy_q && (cnt_q == '0);
  assign done   = reject || finish;

  assign cell_idx   = addr[AW-1:0];
  assign merged     = cell_byte | pdata;
  assign cell_wr    = finish && prog_q;
  assign cell_wbyte = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fail_q  <= 1'b0;
      prog_q  <= 1'b0;
      cnt_q   <= '0;
      rbyte_q <= 8'h00;
    end else if (start) begin
      busy_q <= 1'b1;
      fail_q <= 1'b0;
      prog_q <= func[1];
      cnt_q  <= func[1] ? CW'(PG_LAT - 1) : CW'(RD_LAT - 1);
    end else if (reject) begin
      fail_q <= 1'b1;
    end else if (finish) begin
      busy_q <= 1'b0;
      if (prog_q) begin
        fail_q <= (merged != pdata);
      end else begin
        rbyte_q <= cell_byte;
        fail_q  <= 1'b0;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy  = busy_q;
  assign fail  = fail_q;
  assign rbyte = rbyte_q;

  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_pulse && pwrdn) |=> (fail && !busy));
  p_fail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !fail));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt_q) < MAXLAT));
endmodule

// File: rtl/otpc_regs.sv
module otpc_regs
  import otpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              fail,
  input  logic [7:0]        rbyte,
  input  logic              done,
  output logic              pwrdn,
  output logic [OTP_AW-1:0] otp_addr,
  output logic [7:0]        pdata,
  output logic              byte_mode,
  output logic [1:0]        func,
  output logic              go_pulse,
  output logic [7:0]        rdata
);
  logic       pwrdn_q, mode_q;
  logic [4:0] hi_q;
  logic [7:0] lo_q, pdata_q;
  logic [1:0] func_q;
  logic       wr_ok;

  assign wr_ok    = wr_en && !busy;
  assign go_pulse = wr_ok && (addr == OFF_GO) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrdn_q <= 1'b1;
      mode_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      pdata_q <= '0;
      func_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (addr)
          OFF_PWRDN: pwrdn_q <= wdata[0];
          OFF_ADHI:  hi_q    <= wdata[4:0];
          OFF_ADLO:  lo_q    <= wdata;
          OFF_PDATA: pdata_q <= wdata;
          OFF_MODE:  mode_q  <= wdata[0];
          OFF_FUNC:  func_q  <= wdata[1:0];
          default: ;
        endcase
      end
      if (done) func_q <= '0;
    end
  end

  always_comb begin
    case (addr)
      OFF_PWRDN: rdata = {7'b0, pwrdn_q};
      OFF_ADHI:  rdata = {3'b0, hi_q};
      OFF_ADLO:  rdata = lo_q;
      OFF_PDATA: rdata = pdata_q;
      OFF_MODE:  rdata = {7'b0, mode_q};
      OFF_RDATA: rdata = rbyte;
      OFF_FUNC:  rdata = {6'b0, func_q};
      OFF_GO:    rdata = {7'b0, busy};
      OFF_FAIL:  rdata = {7'b0, fail};
      OFF_STAT:  rdata = {7'b0, busy};
      default:   rdata = 8'h00;
    endcase
  end

  assign pwrdn     = pwrdn_q;
  assign otp_addr  = {hi_q, lo_q};
  assign pdata     = pdata_q;
  assign byte_mode = mode_q;
  assign func      = func_q;

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pwrdn_q) && $stable(hi_q) && $stable(lo_q) &&
              $stable(pdata_q) && $stable(mode_q)));
  p_func_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (func_q == 2'b00));
endmodule

// File: rtl/otpc_top.sv
module otpc_top
  import otpc_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 12,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic              pwrdn, byte_mode, go_pulse, busy, fail, done, cell_wr;
  logic [OTP_AW-1:0] otp_addr;
  logic [7:0]        pdata, rbyte, cell_byte, cell_wbyte;
  logic [1:0]        func;
  logic [AW-1:0]     cell_idx;

  otpc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .fail(fail), .rbyte(rbyte), .done(done),
    .pwrdn(pwrdn), .otp_addr(otp_addr), .pdata(pdata),
    .byte_mode(byte_mode), .func(func), .go_pulse(go_pulse),
    .rdata(reg_rdata)
  );

  otpc_seq #(.ARRAY_BYTES(ARRAY_BYTES), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT))
  u_seq (
    .clk(clk), .rst_n(rst_n), .go_pulse(go_pulse), .pwrdn(pwrdn),
    .func(func), .byte_mode(byte_mode), .addr(otp_addr), .pdata(pdata),
    .cell_byte(cell_byte), .cell_idx(cell_idx), .cell_wr(cell_wr),
    .cell_wbyte(cell_wbyte), .busy(busy), .fail(fail), .rbyte(rbyte),
    .done(done)
  );

  otpc_array #(.DEPTH(ARRAY_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .idx(cell_idx), .wr_en(cell_wr),
    .wr_byte(cell_wbyte), .rd_byte(cell_byte)
  );
endmodule

// File: tb/otpc_top_tb.sv
module otpc_top_tb;
  localparam int RD_LAT = 4;
  localparam int PG_LAT = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  otpc_top #(.ARRAY_BYTES(1024), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  // Monitor: pops expected register values and compares away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s actual %02h expected %02h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    reg_addr = a;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic expect_val(input int act, input int e, input string tag);
    checks++;
    if (act != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic go_measure(output int n);
    wr(6'h28, 8'h01);
    reg_addr = 6'h30;
    n = 0;
    @(negedge clk);
    while (reg_rdata[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    wr(6'h04, hi);
    wr(6'h08, lo);
  endtask

  task automatic do_read(input logic [7:0] hi, input logic [7:0] lo, output int n);
    set_addr(hi, lo);
    wr(6'h20, 8'h01);
    go_measure(n);
  endtask

  task automatic do_prog(input logic [7:0] hi, input logic [7:0] lo,
                         input logic [7:0] d, output int n);
    set_addr(hi, lo);
    wr(6'h14, 8'h01);
    wr(6'h10, d);
    wr(6'h20, 8'h02);
    go_measure(n);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    expect_reg(6'h00, 8'h01, "R1 pwrdn reset");
    expect_reg(6'h30, 8'h00, "R1 status reset");
    expect_reg(6'h2C, 8'h00, "R1 fail reset");
    expect_reg(6'h20, 8'h00, "R1 func reset");

    // R8 go while powered down
    do_read(8'h00, 8'h05, n);
    expect_val(n, 0, "R8 powered down no busy");
    expect_reg(6'h2C, 8'h01, "R8 powered down fail");
    expect_reg(6'h20, 8'h00, "R7 func cleared on reject");

    wr(6'h00, 8'h00);
    expect_reg(6'h00, 8'h00, "R1 pwrdn cleared");

    // R2 high register width, R8 out of range address 0x1F34
    wr(6'h04, 8'hFF);
    expect_reg(6'h04, 8'h1F, "R2 high field width");
    do_read(8'h1F, 8'h34, n);
    expect_val(n, 0, "R8 out of range no busy");
    expect_reg(6'h2C, 8'h01, "R8 out of range fail");

    // R3 read of unprogrammed byte, R10 fail cleared
    do_read(8'h02, 8'h10, n);
    expect_val(n, RD_LAT, "R3 read busy length");
    expect_reg(6'h18, 8'h00, "R1 unprogrammed byte reads zero");
    expect_reg(6'h2C, 8'h00, "R10 fail cleared by accepted op");

    // R4 R6 R7 first program
    do_prog(8'h02, 8'h10, 8'h5A, n);
    expect_val(n, PG_LAT, "R6 program busy length");
    expect_reg(6'h2C, 8'h00, "R4 program pass");
    expect_reg(6'h20, 8'h00, "R7 func cleared");
    expect_reg(6'h28, 8'h00, "R7 go cleared");
    do_read(8'h02, 8'h10, n);
    expect_reg(6'h18, 8'h5A, "R4 programmed byte");

    // R5 verify mismatch: 0x5A | 0x0F = 0x5F
    do_prog(8'h02, 8'h10, 8'h0F, n);
    expect_reg(6'h2C, 8'h01, "R5 verify fail");
    do_read(8'h02, 8'h10, n);
    expect_reg(6'h18, 8'h5F, "R5 ORed byte kept");

    // R8 functions 00, 11, program without byte mode
    set_addr(8'h02, 8'h10);
    wr(6'h10, 8'hFF);
    wr(6'h20, 8'h03);
    go_measure(n);
    expect_val(n, 0, "R8 both bits no busy");
    expect_reg(6'h2C, 8'h01, "R8 both bits fail");
    wr(6'h20, 8'h00);
    go_measure(n);
    expect_reg(6'h2C, 8'h01, "R8 no bits fail");
    wr(6'h14, 8'h00);
    wr(6'h20, 8'h02);
    go_measure(n);
    expect_val(n, 0, "R8 no byte mode no busy");
    expect_reg(6'h2C, 8'h01, "R8 no byte mode fail");
    do_read(8'h02, 8'h10, n);
    expect_reg(6'h18, 8'h5F, "R8 array unchanged by rejects");

    // R2 independence of high part
    do_prog(8'h00, 8'h01, 8'hA5, n);
    do_prog(8'h01, 8'h01, 8'h3C, n);
    do_read(8'h00, 8'h01, n);
    expect_reg(6'h18, 8'hA5, "R2 low page byte");
    do_read(8'h01, 8'h01, n);
    expect_reg(6'h18, 8'h3C, "R2 high page byte");
    do_read(8'h00, 8'h00, n);
    expect_reg(6'h18, 8'h00, "R2 neighbour untouched");

    // R9 writes during busy are ignored
    set_addr(8'h00, 8'h01);
    wr(6'h20, 8'h01);
    wr(6'h28, 8'h01);
    wr(6'h08, 8'h77);
    wr(6'h00, 8'h01);
    repeat (RD_LAT + 4) @(posedge clk);
    expect_reg(6'h08, 8'h01, "R9 address write ignored");
    expect_reg(6'h00, 8'h00, "R9 pwrdn write ignored");
    expect_reg(6'h18, 8'hA5, "R9 read completed");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule